// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block gathers 64 interrupt lines into two banks of 32 bits and drives one interrupt request to a processor. Each bank keeps a set of latched event bits, a software-written enable mask and a copy of the live line levels. A fixed per-bank pattern marks some lines as level-sensitive. A level-sensitive line asks for service only while it is high and never latches an event. Every other line latches an event bit that stays set after the line falls, until software clears it.

Software reaches both banks through a plain 32-bit register bus inside a 4 KB window. Each bank occupies a 16-byte slot: the slot at 0x010 belongs to bank 0 and the slot at 0x020 to bank 1. All lines are sampled on the rising clock edge. The request output is a register that follows the banks' state on the same edge at which that state changes.

Top module: `irqc_dual_bank`

## Requirements
- R1: After a synchronous reset, every event, mask and level register reads zero and `cpu_irq` is low. Bank 0 has no level-sensitive lines, and bank 1 treats its bits 20 to 28 (mask 0x1FF00000) as level-sensitive.
- R2: A bank's level register, read at slot offset 0xC, shows the state of its lines as sampled at the previous rising edge.
- R3: A high line that is not level-sensitive sets its event bit, read at offset 0x0. The bit stays set after the line goes low, until it is acknowledged.
- R4: A level-sensitive line never sets its event bit. It contributes to the request only while its level bit is set.
- R5: A write to offset 0x8 clears each event bit that is set in the write data. When the same bit is also asserted by its line in that cycle, or is still held high, the line wins and the bit stays set.
- R6: Offset 0x4 reads and writes the mask. A bank requests service when (events OR (levels AND level-sensitive)) AND mask is nonzero.
- R7: `cpu_irq` is the OR of both banks' request conditions. It goes high or low one clock after the line, mask or acknowledge change that causes it.
- R8: Line N maps to bank 1-(N>>5), bit N&31. Lines 0 to 31 appear in bank 1 at 0x020, and lines 32 to 63 appear in bank 0 at 0x010.
- R9: The bank index is ((addr mod 0x1000) - 0x10) >> 4, taken modulo 0x1000. Writes to an index of 2 or more do nothing, and reads from such an index return zero. Only offsets 0x0, 0x4 and 0xC give read data; every other offset reads zero. Only offsets 0x4 and 0x8 accept writes.
- R10: Read data is combinational from `bus_re` and `bus_addr` in the same cycle. It is zero whenever `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Interrupt lines, bit N is line N |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_we | input | 1 | Write strobe, acts on the rising edge |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| cpu_irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is an acknowledge that lands on the same edge as a new assertion of the same line. Only there does the set-over-clear priority decide the result. The bench drives the line and the acknowledge write from the same falling edge so that both are seen at one rising edge, and then reads the event register back. Address aliasing is also subtle: addresses below 0x010 wrap to a large bank index. The bench writes there and at index 2, then checks that neither bank's mask moved.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Register offsets within a 16-byte bank slot
  localparam logic [3:0] OFS_EVENT = 4'h0;
  localparam logic [3:0] OFS_MASK  = 4'h4;
  localparam logic [3:0] OFS_ACK   = 4'h8;
  localparam logic [3:0] OFS_LEVEL = 4'hC;
  localparam int unsigned SLOT_LG2 = 4;
endpackage

// File: rtl/irqc_addr_dec.sv
module irqc_addr_dec
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BANK_BASE = 16,
  localparam int unsigned IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned HI_W     = ADDR_W - SLOT_LG2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  bank_idx,
  output logic [3:0]        reg_ofs
);
  logic [HI_W-1:0] slot_rel;

  always_comb begin
    // subtraction wraps modulo the window size
    slot_rel = addr[ADDR_W-1:SLOT_LG2] - HI_W'(BANK_BASE >> SLOT_LG2);
    hit      = (slot_rel < HI_W'(NUM_BANKS));
    bank_idx = slot_rel[IDX_W-1:0];
    reg_ofs  = addr[SLOT_LG2-1:0];
  end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int unsigned         BANK_W  = 32,
  parameter logic [BANK_W-1:0]   LVL_SEL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] line_in,
  input  logic              mask_we,
  input  logic              ack_we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] events,
  output logic [BANK_W-1:0] mask,
  output logic [BANK_W-1:0] levels,
  output logic              req,
  output logic              req_next
);
  logic [BANK_W-1:0] ev_q, mk_q, lv_q;
  logic [BANK_W-1:0] ev_n, mk_n, lv_n, clr_bits, set_bits;

  always_comb begin
    clr_bits = ack_we ? (wdata & ~LVL_SEL) : '0;
    set_bits = line_in & ~LVL_SEL;
    ev_n     = (ev_q & ~clr_bits) | set_bits;  // set beats clear
    lv_n     = line_in;
    mk_n     = mask_we ? wdata : mk_q;
    req_next = |((ev_n | (lv_n & LVL_SEL)) & mk_n);
    req      = |((ev_q | (lv_q & LVL_SEL)) & mk_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q <= '0;
      mk_q <= '0;
      lv_q <= '0;
    end else begin
      ev_q <= ev_n;
      mk_q <= mk_n;
      lv_q <= lv_n;
    end
  end

  assign events = ev_q;
  assign mask   = mk_q;
  assign levels = lv_q;

  // R2
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lv_q == $past(line_in)));
  // R3
  event_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_we |=> ((ev_q & $past(ev_q)) == $past(ev_q)));
  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ack_we |=> ((ev_q & $past(wdata & ~line_in & ~LVL_SEL)) == '0));
  // R4
  lvl_no_event_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_q & LVL_SEL) == '0);
  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mask_we |=> $stable(mk_q));
endmodule

// File: rtl/irqc_dual_bank.sv
module irqc_dual_bank
  import irqc_pkg::*;
#(
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BANK_BASE = 16,
  parameter logic [NUM_BANKS*BANK_W-1:0] LVL_SEL_ALL = {32'h1FF0_0000, 32'h0000_0000},
  localparam int unsigned NUM_IN   = NUM_BANKS * BANK_W,
  localparam int unsigned IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [BANK_W-1:0] bus_wdata,
  output logic [BANK_W-1:0] bus_rdata,
  output logic              cpu_irq
);
  logic             hit;
  logic [IDX_W-1:0] bank_idx;
  logic [3:0]       reg_ofs;

  logic [BANK_W-1:0]    ev_arr [NUM_BANKS];
  logic [BANK_W-1:0]    mk_arr [NUM_BANKS];
  logic [BANK_W-1:0]    lv_arr [NUM_BANKS];
  logic [NUM_BANKS-1:0] req_vec, req_next_vec, mask_we_vec, ack_we_vec;
  logic                 cpu_irq_q;

  irqc_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_BASE(BANK_BASE)
  ) u_dec (
    .addr(bus_addr), .hit(hit), .bank_idx(bank_idx), .reg_ofs(reg_ofs)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    // line N goes to bank (NUM_BANKS-1) - N/BANK_W
    localparam int unsigned LINE_LO = (NUM_BANKS - 1 - b) * BANK_W;
    logic sel;
    assign sel            = hit && (bank_idx == IDX_W'(b));
    assign mask_we_vec[b] = bus_we && sel && (reg_ofs == OFS_MASK);
    assign ack_we_vec[b]  = bus_we && sel && (reg_ofs == OFS_ACK);

    irqc_bank #(
      .BANK_W(BANK_W), .LVL_SEL(LVL_SEL_ALL[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk(clk), .rst(rst),
      .line_in(irq_in[LINE_LO +: BANK_W]),
      .mask_we(mask_we_vec[b]), .ack_we(ack_we_vec[b]),
      .wdata(bus_wdata),
      .events(ev_arr[b]), .mask(mk_arr[b]), .levels(lv_arr[b]),
      .req(req_vec[b]), .req_next(req_next_vec[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re && hit) begin
      case (reg_ofs)
        OFS_EVENT: bus_rdata = ev_arr[bank_idx];
        OFS_MASK:  bus_rdata = mk_arr[bank_idx];
        OFS_LEVEL: bus_rdata = lv_arr[bank_idx];
        default:   bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_irq_q <= 1'b0;
    else     cpu_irq_q <= |req_next_vec;
  end
  assign cpu_irq = cpu_irq_q;

  // R7
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_irq == (|req_vec));
  // R9
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mask_we_vec, ack_we_vec}));
  // R10
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_re |-> (bus_rdata == '0));
endmodule

// File: tb/irqc_dual_bank_tb.sv
`timescale 1ns/1ps
module irqc_dual_bank_tb;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IN = 2'd2, OP_IQ = 2'd3;
  localparam int NV = 58;
  // {requirement, op, address, data}
  localparam logic [81:0] VECS [NV] = '{
    {4'd1, OP_RD, 12'h010, 64'h0},                 // R1
    {4'd1, OP_RD, 12'h014, 64'h0},                 // R1
    {4'd1, OP_RD, 12'h01C, 64'h0},                 // R1
    {4'd1, OP_RD, 12'h020, 64'h0},                 // R1
    {4'd1, OP_RD, 12'h024, 64'h0},                 // R1
    {4'd1, OP_RD, 12'h02C, 64'h0},                 // R1
    {4'd7, OP_IQ, 12'h000, 64'h0},                 // R7
    {4'd8, OP_IN, 12'h000, 64'h0000_0100_0000_0000}, // R8 line 40
    {4'd2, OP_RD, 12'h01C, 64'h100},               // R2
    {4'd3, OP_RD, 12'h010, 64'h100},               // R3
    {4'd6, OP_IQ, 12'h000, 64'h0},                 // R6 masked off
    {4'd6, OP_WR, 12'h014, 64'h100},               // R6
    {4'd6, OP_RD, 12'h014, 64'h100},               // R6
    {4'd7, OP_IQ, 12'h000, 64'h1},                 // R7
    {4'd3, OP_IN, 12'h000, 64'h0},                 // R3
    {4'd2, OP_RD, 12'h01C, 64'h0},                 // R2
    {4'd3, OP_RD, 12'h010, 64'h100},               // R3 sticky
    {4'd7, OP_IQ, 12'h000, 64'h1},                 // R7
    {4'd5, OP_WR, 12'h018, 64'h100},               // R5
    {4'd5, OP_RD, 12'h010, 64'h0},                 // R5
    {4'd7, OP_IQ, 12'h000, 64'h0},                 // R7
    {4'd8, OP_IN, 12'h000, 64'h20},                // R8 line 5
    {4'd8, OP_RD, 12'h02C, 64'h20},                // R8
    {4'd8, OP_RD, 12'h020, 64'h20},                // R8
    {4'd8, OP_RD, 12'h01C, 64'h0},                 // R8
    {4'd5, OP_WR, 12'h028, 64'h20},                // R5 line still high
    {4'd5, OP_RD, 12'h020, 64'h20},                // R5
    {4'd5, OP_IN, 12'h000, 64'h0},                 // R5
    {4'd5, OP_WR, 12'h028, 64'h20},                // R5
    {4'd5, OP_RD, 12'h020, 64'h0},                 // R5
    {4'd4, OP_IN, 12'h000, 64'h0100_0000},         // R4 line 24
    {4'd4, OP_RD, 12'h02C, 64'h0100_0000},         // R4
    {4'd4, OP_RD, 12'h020, 64'h0},                 // R4 no event
    {4'd4, OP_IQ, 12'h000, 64'h0},                 // R4
    {4'd4, OP_WR, 12'h024, 64'h0100_0000},         // R4
    {4'd4, OP_RD, 12'h024, 64'h0100_0000},         // R4
    {4'd4, OP_IQ, 12'h000, 64'h1},                 // R4
    {4'd5, OP_WR, 12'h028, 64'hFFFF_FFFF},         // R5
    {4'd4, OP_IQ, 12'h000, 64'h1},                 // R4
    {4'd4, OP_IN, 12'h000, 64'h0},                 // R4
    {4'd4, OP_IQ, 12'h000, 64'h0},                 // R4
    {4'd9, OP_WR, 12'h030, 64'hFFFF},              // R9
    {4'd9, OP_WR, 12'h004, 64'hFFFF},              // R9 wraps
    {4'd9, OP_WR, 12'h034, 64'h0},                 // R9
    {4'd9, OP_WR, 12'h010, 64'hFFFF},              // R9
    {4'd9, OP_WR, 12'h01C, 64'hFFFF},              // R9
    {4'd9, OP_RD, 12'h014, 64'h100},               // R9
    {4'd9, OP_RD, 12'h024, 64'h0100_0000},         // R9
    {4'd9, OP_RD, 12'h010, 64'h0},                 // R9
    {4'd9, OP_RD, 12'h034, 64'h0},                 // R9
    {4'd9, OP_RD, 12'h004, 64'h0},                 // R9
    {4'd9, OP_RD, 12'h018, 64'h0},                 // R9
    {4'd9, OP_RD, 12'h015, 64'h0},                 // R9
    {4'd8, OP_IN, 12'h000, 64'h8000_0000_0000_0000}, // R8 line 63
    {4'd8, OP_RD, 12'h01C, 64'h8000_0000},         // R8
    {4'd8, OP_RD, 12'h02C, 64'h0},                 // R8
    {4'd7, OP_IQ, 12'h000, 64'h0},                 // R7
    {4'd8, OP_IN, 12'h000, 64'h0}                  // R8
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_in = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irqc_dual_bank u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
  );

  task automatic chk(input int rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic rd(input int rq, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a; bus_re = 1'b1; #1;
    chk(rq, {32'h0, bus_rdata}, {32'h0, exp});
    bus_re = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_we = 1'b0; bus_re = 1'b0;
      case (VECS[i][77:76])
        OP_WR: begin
          bus_addr = VECS[i][75:64]; bus_wdata = VECS[i][31:0]; bus_we = 1'b1;
        end
        OP_RD: rd(int'(VECS[i][81:78]), VECS[i][75:64], VECS[i][31:0]);
        OP_IN: irq_in = VECS[i][63:0];
        default: chk(int'(VECS[i][81:78]), {63'h0, cpu_irq}, VECS[i][63:0]);
      endcase
    end
    @(negedge clk); bus_we = 1'b0;
    // R10: read strobe low gives zero, high gives data in the same cycle
    bus_addr = 12'h014; bus_re = 1'b0; #1;
    chk(10, {32'h0, bus_rdata}, 64'h0);   // R10
    bus_re = 1'b1; #1;
    chk(10, {32'h0, bus_rdata}, 64'h100); // R10
    bus_re = 1'b0;
    // R5: line 3 asserts at the same edge that acknowledges bank 1 bit 3
    @(negedge clk);
    irq_in = 64'h8; bus_addr = 12'h028; bus_wdata = 32'h8; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; irq_in = 64'h0;
    rd(5, 12'h020, 32'h8);                // R5 set wins
    // R1: reset from a dirty state
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    rd(1, 12'h010, 32'h0);                // R1
    rd(1, 12'h014, 32'h0);                // R1
    rd(1, 12'h020, 32'h0);                // R1
    rd(1, 12'h024, 32'h0);                // R1
    chk(1, {63'h0, cpu_irq}, 64'h0);      // R1
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule